// File: doc/BRIEF.md
# Display Pipe Frame Status Unit

This block follows the frame timing of a single display pipe. Three single-cycle pulses come in from the timing generator: one at the start of vertical blank, one at the later frame-start point inside vertical blank, and one at horizontal blank. The block counts frames and keeps sticky write-one-to-clear flags for the frame-start and horizontal-blank events. It drives a level interrupt whenever an enabled flag is set.

A configuration word goes through two buffer stages. Software may write the pending copy at any time. The start of vertical blank copies the pending value into an armed copy. The frame-start pulse then moves the armed value into the active copy that drives the pipeline. A write made after vertical blank has begun therefore waits a whole frame. Software can clear the frame-start flag and then poll it to find out when a new setting has taken hold.

Top module: `disp_frame_stat`

## Requirements
- R1: The frame counter (CNT_W bits, default 32, read zero-extended at byte offset 0x71040) resets to zero. It rises by exactly one on each cycle in which `vblank_start_i` is high and holds its value on every other cycle.
- R2: The frame counter wraps from all ones to zero.
- R3: A `frame_start_i` pulse sets status bit 1 (offset 0x71048) on the next clock edge. A vertical-blank-start pulse does not set it.
- R4: An `hblank_i` pulse sets status bit 0 on the next clock edge.
- R5: A write to the status register clears each bit written as one. Bits written as zero keep their value.
- R6: If an event pulse and a write-one-to-clear of the same status bit arrive in the same cycle, the bit ends up set.
- R7: A write to offset 0x71050 updates the pending configuration, which reads back at that offset. A vertical-blank-start pulse copies pending into armed. A frame-start pulse copies armed into active. The active value appears on `cfg_active_o` and reads at 0x71054, and it changes on no other event.
- R8: A configuration write made between a vertical-blank start and the frame start that follows it does not reach the active value at that frame start. It reaches the active value at the next frame start after the following vertical-blank start.
- R9: `irq_o` is high exactly while some status bit is set and its enable bit is one. The enable register sits at offset 0x7104C: bit 0 enables horizontal blank and bit 1 enables frame start.
- R10: Read data appears on `reg_rdata_o` in the cycle after the read strobe and is zero in any cycle that does not follow a strobe. The flip-counter word at 0x71044 and every unmapped offset read zero, and writes to them change no register.
- R11: After reset the status register, the enable register and all three configuration copies hold their reset values: zero for status and enable, and CFG_RST for the configuration copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vblank_start_i | input | 1 | Pulse at start of vertical blank |
| frame_start_i | input | 1 | Pulse at frame-start point inside vertical blank |
| hblank_i | input | 1 | Pulse at horizontal blank |
| reg_addr_i | input | 20 | Register byte address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one cycle after the strobe |
| irq_o | output | 1 | Level interrupt |
| cfg_active_o | output | CFG_W | Active configuration value |

## Verification
The bench builds the block with CNT_W = 8, CFG_W = 16 and a non-zero CFG_RST. With an 8-bit counter, the wrap from 255 to zero is reached after a few hundred vertical-blank pulses rather than 2^32 of them. The non-zero configuration reset value makes a missed copy between the pending, armed and active stages show up as a wrong value rather than a zero. A read scoreboard covers the two-stage configuration timing, including a write placed between vertical blank and frame start. It also covers the same-cycle set-and-clear race.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  localparam int unsigned ADDR_W = 20;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned N_EVT  = 2;
  localparam int unsigned EVT_HB = 0;
  localparam int unsigned EVT_FS = 1;

  typedef logic [ADDR_W-1:0] reg_addr_t;
  typedef logic [DATA_W-1:0] reg_data_t;

  localparam reg_addr_t OFF_FRAME_CNT = 20'h71040;
  localparam reg_addr_t OFF_FLIP      = 20'h71044;
  localparam reg_addr_t OFF_STATUS    = 20'h71048;
  localparam reg_addr_t OFF_IRQ_EN    = 20'h7104C;
  localparam reg_addr_t OFF_CFG_PEND  = 20'h71050;
  localparam reg_addr_t OFF_CFG_ACT   = 20'h71054;
endpackage

// File: rtl/dfs_frame_cnt.sv
module dfs_frame_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dfs_sticky_stat.sv
module dfs_sticky_stat #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        stat_o[g] <= 1'b0;
      else if (set_i[g])  stat_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g])  stat_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/dfs_cfg_dbuf.sv
module dfs_cfg_dbuf #(
  parameter int unsigned          W   = 32,
  parameter logic [W-1:0]         RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         arm_i,
  input  logic         commit_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] armed_o,
  output logic [W-1:0] active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o   <= RST;
      armed_o  <= RST;
      active_o <= RST;
    end else begin
      if (wr_i)     pend_o   <= wdata_i;
      if (arm_i)    armed_o  <= pend_o;
      if (commit_i) active_o <= armed_o;
    end
  end
endmodule

// File: rtl/disp_frame_stat.sv
module disp_frame_stat
  import dfs_pkg::*;
#(
  parameter int unsigned      CNT_W   = 32,
  parameter int unsigned      CFG_W   = 32,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vblank_start_i,
  input  logic                frame_start_i,
  input  logic                hblank_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_o,
  output logic [CFG_W-1:0]    cfg_active_o
);
  logic [CNT_W-1:0] frame_cnt;
  logic [N_EVT-1:0] stat_q, stat_set, stat_clr, irq_en_q;
  logic [CFG_W-1:0] cfg_pend, cfg_armed;
  logic             wr_stat, wr_en, wr_cfg;
  reg_data_t        rd_mux;

  assign wr_stat = reg_wr_i && (reg_addr_i == OFF_STATUS);
  assign wr_en   = reg_wr_i && (reg_addr_i == OFF_IRQ_EN);
  assign wr_cfg  = reg_wr_i && (reg_addr_i == OFF_CFG_PEND);

  assign stat_set[EVT_HB] = hblank_i;
  assign stat_set[EVT_FS] = frame_start_i;
  assign stat_clr         = wr_stat ? reg_wdata_i[N_EVT-1:0] : '0;

  dfs_frame_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (vblank_start_i),
    .cnt_o  (frame_cnt)
  );

  dfs_sticky_stat #(.N(N_EVT)) i_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (stat_set),
    .clr_i  (stat_clr),
    .stat_o (stat_q)
  );

  dfs_cfg_dbuf #(.W(CFG_W), .RST(CFG_RST)) i_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_cfg),
    .wdata_i  (reg_wdata_i[CFG_W-1:0]),
    .arm_i    (vblank_start_i),
    .commit_i (frame_start_i),
    .pend_o   (cfg_pend),
    .armed_o  (cfg_armed),
    .active_o (cfg_active_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_en_q <= '0;
    else if (wr_en) irq_en_q <= reg_wdata_i[N_EVT-1:0];
  end

  assign irq_o = |(stat_q & irq_en_q);

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr_i)
      OFF_FRAME_CNT: rd_mux = DATA_W'(frame_cnt);
      OFF_STATUS:    rd_mux = DATA_W'(stat_q);
      OFF_IRQ_EN:    rd_mux = DATA_W'(irq_en_q);
      OFF_CFG_PEND:  rd_mux = DATA_W'(cfg_pend);
      OFF_CFG_ACT:   rd_mux = DATA_W'(cfg_active_o);
      default:       rd_mux = '0;  // flip word and unmapped
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_rdata_o <= '0;
    else         reg_rdata_o <= reg_rd_i ? rd_mux : '0;
  end
endmodule

// File: rtl/dfs_checker.sv
module dfs_checker
  import dfs_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned CFG_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vblank_start_i,
  input logic              frame_start_i,
  input logic              hblank_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_o,
  input logic [CFG_W-1:0]  cfg_active_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [N_EVT-1:0]  stat_i,
  input logic [CFG_W-1:0]  armed_i
);
  logic wr_stat;
  assign wr_stat = reg_wr_i && (reg_addr_i == OFF_STATUS);

  p_cnt_inc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_start_i |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));
  p_cnt_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vblank_start_i |=> $stable(cnt_i));
  p_fs_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> stat_i[EVT_FS]);
  p_hb_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hblank_i |=> stat_i[EVT_HB]);
  p_w1c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && reg_wdata_i[EVT_HB] && !hblank_i) |=> !stat_i[EVT_HB]);
  p_w0_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i[EVT_FS] && !(wr_stat && reg_wdata_i[EVT_FS])) |=> stat_i[EVT_FS]);
  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && reg_wdata_i[EVT_FS] && frame_start_i) |=> stat_i[EVT_FS]);
  p_act_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(cfg_active_o));
  p_act_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> cfg_active_o == $past(armed_i));
  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_i != '0));
  p_rd_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> reg_rdata_o == '0);
  p_flip_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == OFF_FLIP) |=> reg_rdata_o == '0);
endmodule

bind disp_frame_stat dfs_checker #(.CNT_W(CNT_W), .CFG_W(CFG_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .vblank_start_i (vblank_start_i),
  .frame_start_i  (frame_start_i),
  .hblank_i       (hblank_i),
  .reg_addr_i     (reg_addr_i),
  .reg_wr_i       (reg_wr_i),
  .reg_rd_i       (reg_rd_i),
  .reg_wdata_i    (reg_wdata_i),
  .reg_rdata_o    (reg_rdata_o),
  .irq_o          (irq_o),
  .cfg_active_o   (cfg_active_o),
  .cnt_i          (frame_cnt),
  .stat_i         (stat_q),
  .armed_i        (cfg_armed)
);

// File: tb/test_disp_frame_stat.sv
`timescale 1ns/1ps
module test_disp_frame_stat;
  import dfs_pkg::*;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned CFG_W   = 16;
  localparam logic [15:0] CFG_RST = 16'h1234;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic vbs = 1'b0, fs = 1'b0, hb = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic irq;
  logic [CFG_W-1:0] cfg_act;

  int n_chk = 0, n_fail = 0;
  int exp_cnt = 0;
  logic [DATA_W-1:0] q_exp[$];
  string q_tag[$];
  logic rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  disp_frame_stat #(.CNT_W(CNT_W), .CFG_W(CFG_W), .CFG_RST(CFG_RST)) i_disp_frame_stat (
    .clk_i(clk), .rst_ni(rst_ni), .vblank_start_i(vbs), .frame_start_i(fs),
    .hblank_i(hb), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .cfg_active_o(cfg_act)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_seen <= rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (q_exp.size() == 0) check("R10 unexpected read data", rdata, '0);
      else check(q_tag.pop_front(), rdata, q_exp.pop_front());
    end
  end

  // driver tasks: called at a negedge, return at a later negedge
  task automatic rd_exp(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    q_exp.push_back(e); q_tag.push_back(tag);
    addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse_vbs();
    vbs = 1'b1; exp_cnt = (exp_cnt + 1) % (1 << CNT_W);
    @(negedge clk); vbs = 1'b0;
  endtask

  task automatic pulse_fs();
    fs = 1'b1; @(negedge clk); fs = 1'b0;
  endtask

  task automatic pulse_hb();
    hb = 1'b1; @(negedge clk); hb = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 / R1 reset state
    check("R11 irq after reset", DATA_W'(irq), 0);
    check("R11 cfg_active_o after reset", DATA_W'(cfg_act), DATA_W'(CFG_RST));
    check("R10 rdata idle", rdata, '0);
    rd_exp(OFF_FRAME_CNT, 0, "R1 counter reset");
    rd_exp(OFF_STATUS, 0, "R11 status reset");
    rd_exp(OFF_IRQ_EN, 0, "R11 enable reset");
    rd_exp(OFF_CFG_PEND, DATA_W'(CFG_RST), "R11 pending reset");
    rd_exp(OFF_CFG_ACT, DATA_W'(CFG_RST), "R11 active reset");

    // R1 counting, R3 vblank does not set frame-start flag
    repeat (3) pulse_vbs();
    @(negedge clk);
    rd_exp(OFF_FRAME_CNT, DATA_W'(exp_cnt), "R1 three vblanks");
    rd_exp(OFF_STATUS, 0, "R3 vblank leaves status");
    pulse_fs(); pulse_hb();
    rd_exp(OFF_FRAME_CNT, DATA_W'(exp_cnt), "R1 no count on fs/hb");

    // R4, R3
    rd_exp(OFF_STATUS, 3, "R4 R3 both flags set");
    // R5
    wr_reg(OFF_STATUS, 0);
    rd_exp(OFF_STATUS, 3, "R5 write zero keeps");
    wr_reg(OFF_STATUS, 1);
    rd_exp(OFF_STATUS, 2, "R5 clear bit0");
    wr_reg(OFF_STATUS, 2);
    rd_exp(OFF_STATUS, 0, "R5 clear bit1");

    // R6 set wins over clear
    hb = 1'b1; fs = 1'b1;
    wr_reg(OFF_STATUS, 3);
    hb = 1'b0; fs = 1'b0;
    rd_exp(OFF_STATUS, 3, "R6 set beats clear");
    wr_reg(OFF_STATUS, 3);

    // R9 interrupt
    pulse_hb();
    check("R9 irq masked", DATA_W'(irq), 0);
    wr_reg(OFF_IRQ_EN, 1);
    check("R9 irq hb enabled", DATA_W'(irq), 1);
    wr_reg(OFF_STATUS, 1);
    check("R9 irq drops on clear", DATA_W'(irq), 0);
    wr_reg(OFF_IRQ_EN, 2);
    pulse_hb();
    check("R9 hb with fs-only enable", DATA_W'(irq), 0);
    pulse_fs();
    check("R9 irq fs enabled", DATA_W'(irq), 1);
    wr_reg(OFF_STATUS, 3);
    check("R9 irq cleared", DATA_W'(irq), 0);
    wr_reg(OFF_IRQ_EN, 0);

    // R7 two-stage config
    wr_reg(OFF_CFG_PEND, 32'h0000BEEF);
    rd_exp(OFF_CFG_PEND, 32'h0000BEEF, "R7 pending readback");
    check("R7 active unchanged by write", DATA_W'(cfg_act), DATA_W'(CFG_RST));
    pulse_vbs();
    check("R7 active unchanged by vblank", DATA_W'(cfg_act), DATA_W'(CFG_RST));
    pulse_fs();
    check("R7 active after fs", DATA_W'(cfg_act), 32'h0000BEEF);
    rd_exp(OFF_CFG_ACT, 32'h0000BEEF, "R7 active readback");

    // R8 late write waits a frame
    pulse_vbs();
    wr_reg(OFF_CFG_PEND, 32'h00005555);
    pulse_fs();
    check("R8 late write not yet active", DATA_W'(cfg_act), 32'h0000BEEF);
    pulse_vbs();
    check("R8 still old before fs", DATA_W'(cfg_act), 32'h0000BEEF);
    pulse_fs();
    check("R8 active next frame", DATA_W'(cfg_act), 32'h00005555);
    wr_reg(OFF_STATUS, 3);

    // R10 flip word, unmapped, ignored writes
    rd_exp(OFF_FLIP, 0, "R10 flip reads zero");
    wr_reg(OFF_FLIP, '1);
    rd_exp(OFF_FLIP, 0, "R10 flip write ignored");
    wr_reg(20'h71060, '1);
    rd_exp(20'h71060, 0, "R10 unmapped reads zero");
    rd_exp(OFF_STATUS, 0, "R10 status untouched");
    rd_exp(OFF_IRQ_EN, 0, "R10 enable untouched");
    rd_exp(OFF_CFG_PEND, 32'h00005555, "R10 pending untouched");
    rd_exp(OFF_FRAME_CNT, DATA_W'(exp_cnt), "R10 counter untouched");
    @(negedge clk);
    check("R10 rdata zero without read", rdata, '0);

    // R2 wrap
    while (exp_cnt != (1 << CNT_W) - 1) pulse_vbs();
    rd_exp(OFF_FRAME_CNT, DATA_W'(exp_cnt), "R2 counter at max");
    pulse_vbs();
    rd_exp(OFF_FRAME_CNT, 0, "R2 counter wrapped");

    repeat (3) @(negedge clk);
    check("R10 scoreboard drained", DATA_W'(q_exp.size()), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule